// File: doc/BRIEF.md
# Receive Cell Output Queue

This block sits between a receive cell source and an ATM-layer device on a UTOPIA-style byte-wide output port. It stores up to four complete 53-byte cells and presents them one byte per clock. The first byte of every cell is marked with `out_soc`. A cell is offered for output only once all of its bytes have been stored. The ATM layer holds off the stream by driving the active-low `atm_enb_n` high. Transfer resumes at the byte where it stopped once the enable returns low.

A cell whose start byte arrives while four cells are already stored is dropped whole, so the stored cells are left intact. The drop sets the sticky `ovf_status` bit. Software clears that bit by writing 0 to it through `sts_wr`/`sts_wdata`. `irq` is raised while both the status bit and `irq_en` are set.

Writing runs in a state machine with the states WR_IDLE, WR_FILL and WR_DROP. Its transitions are:
- WR_IDLE to WR_FILL: a start byte arrives and there is room.
- WR_IDLE to WR_DROP: a start byte arrives while the queue is full.
- WR_FILL to WR_IDLE: the last byte is stored and the cell is committed.
- WR_DROP to WR_IDLE: the last byte of the dropped cell has been consumed.

Reading runs in a state machine with the states RD_IDLE and RD_SEND. Its transitions are:
- RD_IDLE to RD_SEND: a stored cell exists, the enable is low, and byte 0 is sent.
- RD_SEND stays in RD_SEND while the enable is high (stall).
- RD_SEND to RD_IDLE: the last byte is sent and the cell is released.

Top module: `utopia_rx_cellq`

## Requirements
- R1: After reset, `out_valid`, `out_soc`, `ovf_status` and `irq` are all 0.
- R2: Each cell leaves as exactly 53 bytes, in the order they were written. `out_soc` is 1 on byte 0 only.
- R3: A cell whose last byte is taken at clock edge k has its byte 0 presented after edge k+1, provided the enable is low. Before edge k+1 nothing is presented.
- R4: When `atm_enb_n` is 1 at an edge, `out_valid` is 0 after that edge. The next byte presented afterwards is the one following the last byte sent.
- R5: Up to four cells are held. They leave in arrival order, and the stored count never exceeds four.
- R6: A cell that starts while four cells are stored is discarded in full. The four stored cells still leave intact, and no fifth cell follows them.
- R7: A discard sets `ovf_status` at the edge that takes the start byte. The bit then stays 1 until it is cleared.
- R8: A write with `sts_wr`=1 and `sts_wdata`=0 clears `ovf_status` at that edge. A write with `sts_wdata`=1 leaves it unchanged.
- R9: `irq` is 1 exactly when both `ovf_status` and `irq_en` are 1.
- R10: Input bytes with `in_soc`=0 that arrive while no cell is being received are ignored. They cause no output and do not disturb the next cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_soc | input | 1 | Input byte is byte 0 of a cell |
| in_data | input | 8 | Input byte |
| atm_enb_n | input | 1 | Active-low output enable from the ATM layer |
| out_valid | output | 1 | Output byte present |
| out_soc | output | 1 | Output byte is byte 0 of a cell |
| out_data | output | 8 | Output byte |
| sts_wr | input | 1 | Software write strobe for the overflow status |
| sts_wdata | input | 1 | Written value; 0 clears the status |
| ovf_status | output | 1 | Sticky overflow status |
| irq_en | input | 1 | Overflow interrupt enable |
| irq | output | 1 | Overflow interrupt |

## Verification
The bench drives inputs just after each falling edge and samples at the falling edges, so every result is read half a cycle after the edge that makes it.

- Cell commit: the bench expects nothing at the first falling edge after the last input byte, and byte 0 with start-of-cell at the second.
- Enable: a high enable at an edge must leave `out_valid` low at the next falling edge.
- Overflow status: it must read 1 at the falling edge right after the dropped cell's start byte.
- Status clear: a clear must show at the falling edge after the write.
- Interrupt: `irq` follows its inputs in the same cycle.

A byte-level monitor compares every output byte with an arithmetic pattern keyed by cell number and byte index. Several enable patterns are swept: always on, held off, one in three off, and a pseudo-random pattern.

// File: rtl/cellq_pkg.sv
package cellq_pkg;
    typedef enum logic [1:0] {
        WR_IDLE = 2'd0,
        WR_FILL = 2'd1,
        WR_DROP = 2'd2
    } wr_state_t;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_SEND = 1'b1
    } rd_state_t;
endpackage

// File: rtl/cellq_wr_ctrl.sv
module cellq_wr_ctrl #(
    parameter int CELL_BYTES = 53,
    parameter int DEPTH      = 4,
    localparam int IDX_W     = $clog2(CELL_BYTES),
    localparam int SLOT_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_soc,
    input  logic              full,
    output logic              mem_we,
    output logic [SLOT_W-1:0] mem_slot,
    output logic [IDX_W-1:0]  mem_idx,
    output logic              commit,
    output logic              drop_start
);
    import cellq_pkg::*;

    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(CELL_BYTES - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(DEPTH - 1);

    wr_state_t         state, state_nx;
    logic [IDX_W-1:0]  idx;
    logic [SLOT_W-1:0] slot;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= WR_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            WR_IDLE: if (in_valid && in_soc) state_nx = full ? WR_DROP : WR_FILL;
            WR_FILL: if (in_valid && idx == LAST_IDX) state_nx = WR_IDLE;
            WR_DROP: if (in_valid && idx == LAST_IDX) state_nx = WR_IDLE;
            default: state_nx = WR_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_we     = 1'b0;
        commit     = 1'b0;
        drop_start = 1'b0;
        unique case (state)
            WR_IDLE: begin
                mem_we     = in_valid && in_soc && !full;
                drop_start = in_valid && in_soc && full;
            end
            WR_FILL: begin
                mem_we = in_valid;
                commit = in_valid && idx == LAST_IDX;
            end
            WR_DROP: ;
            default: ;
        endcase
    end

    assign mem_slot = slot;
    assign mem_idx  = idx;

    // byte index and slot pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx  <= '0;
            slot <= '0;
        end else begin
            if (state_nx == WR_IDLE)
                idx <= '0;
            else if (in_valid)
                idx <= idx + 1'b1;
            if (commit)
                slot <= (slot == LAST_SLOT) ? '0 : slot + 1'b1;
        end
    end
endmodule

// File: rtl/cellq_rd_ctrl.sv
module cellq_rd_ctrl #(
    parameter int DATA_W     = 8,
    parameter int CELL_BYTES = 53,
    parameter int DEPTH      = 4,
    localparam int IDX_W     = $clog2(CELL_BYTES),
    localparam int SLOT_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enb_n,
    input  logic              avail,
    input  logic [DATA_W-1:0] rd_data,
    output logic [SLOT_W-1:0] rd_slot,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              pop,
    output logic              out_valid,
    output logic              out_soc,
    output logic [DATA_W-1:0] out_data
);
    import cellq_pkg::*;

    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(CELL_BYTES - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(DEPTH - 1);

    rd_state_t         state, state_nx;
    logic [IDX_W-1:0]  idx;
    logic [SLOT_W-1:0] slot;
    logic              fire;

    always_comb begin
        fire = 1'b0;
        unique case (state)
            RD_IDLE: fire = !enb_n && avail;
            RD_SEND: fire = !enb_n;
            default: fire = 1'b0;
        endcase
    end

    assign pop     = fire && idx == LAST_IDX;
    assign rd_slot = slot;
    assign rd_idx  = idx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RD_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            RD_IDLE: if (fire && !pop) state_nx = RD_SEND;
            RD_SEND: if (pop)          state_nx = RD_IDLE;
            default: state_nx = RD_IDLE;
        endcase
    end

    // registered outputs and pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_soc   <= 1'b0;
            out_data  <= '0;
            idx       <= '0;
            slot      <= '0;
        end else begin
            out_valid <= fire;
            out_soc   <= fire && idx == '0;
            if (fire) begin
                out_data <= rd_data;
                idx      <= pop ? '0 : idx + 1'b1;
            end
            if (pop)
                slot <= (slot == LAST_SLOT) ? '0 : slot + 1'b1;
        end
    end
endmodule

// File: rtl/cellq_store.sv
module cellq_store #(
    parameter int DATA_W     = 8,
    parameter int CELL_BYTES = 53,
    parameter int DEPTH      = 4,
    localparam int IDX_W     = $clog2(CELL_BYTES),
    localparam int SLOT_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int ENTRIES   = DEPTH * CELL_BYTES,
    localparam int ADDR_W    = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [ENTRIES];
    logic [ADDR_W-1:0] wr_addr, rd_addr;

    assign wr_addr = ADDR_W'(wr_slot) * ADDR_W'(CELL_BYTES) + ADDR_W'(wr_idx);
    assign rd_addr = ADDR_W'(rd_slot) * ADDR_W'(CELL_BYTES) + ADDR_W'(rd_idx);

    always_ff @(posedge clk) begin
        if (we) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/cellq_status.sv
module cellq_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic sw_we,
    input  logic sw_wdata,
    input  logic irq_en,
    output logic sts,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (!rst_n)                sts <= 1'b0;
        else if (set)              sts <= 1'b1;
        else if (sw_we && !sw_wdata) sts <= 1'b0;
    end

    assign irq = sts && irq_en;
endmodule

// File: rtl/utopia_rx_cellq.sv
module utopia_rx_cellq #(
    parameter int DATA_W     = 8,
    parameter int CELL_BYTES = 53,
    parameter int DEPTH      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_soc,
    input  logic [DATA_W-1:0] in_data,
    input  logic              atm_enb_n,
    output logic              out_valid,
    output logic              out_soc,
    output logic [DATA_W-1:0] out_data,
    input  logic              sts_wr,
    input  logic              sts_wdata,
    output logic              ovf_status,
    input  logic              irq_en,
    output logic              irq
);
    localparam int IDX_W  = $clog2(CELL_BYTES);
    localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W  = $clog2(DEPTH + 1);

    logic [OCC_W-1:0]  occ;
    logic              full, commit, pop, drop_start, mem_we;
    logic [SLOT_W-1:0] wr_slot, rd_slot;
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic [DATA_W-1:0] rd_data;

    assign full = (occ == OCC_W'(DEPTH));

    // committed-cell count
    always_ff @(posedge clk) begin
        if (!rst_n) occ <= '0;
        else begin
            unique case ({commit, pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    cellq_wr_ctrl #(.CELL_BYTES(CELL_BYTES), .DEPTH(DEPTH)) u_wr (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_soc(in_soc),
        .full(full), .mem_we(mem_we), .mem_slot(wr_slot), .mem_idx(wr_idx),
        .commit(commit), .drop_start(drop_start)
    );

    cellq_store #(.DATA_W(DATA_W), .CELL_BYTES(CELL_BYTES), .DEPTH(DEPTH)) u_store (
        .clk(clk), .we(mem_we), .wr_slot(wr_slot), .wr_idx(wr_idx),
        .wr_data(in_data), .rd_slot(rd_slot), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    cellq_rd_ctrl #(.DATA_W(DATA_W), .CELL_BYTES(CELL_BYTES), .DEPTH(DEPTH)) u_rd (
        .clk(clk), .rst_n(rst_n), .enb_n(atm_enb_n), .avail(occ != '0),
        .rd_data(rd_data), .rd_slot(rd_slot), .rd_idx(rd_idx), .pop(pop),
        .out_valid(out_valid), .out_soc(out_soc), .out_data(out_data)
    );

    cellq_status u_sts (
        .clk(clk), .rst_n(rst_n), .set(drop_start), .sw_we(sts_wr),
        .sw_wdata(sts_wdata), .irq_en(irq_en), .sts(ovf_status), .irq(irq)
    );
endmodule

// File: rtl/utopia_rx_cellq_chk.sv
module utopia_rx_cellq_chk #(
    parameter int DEPTH = 4,
    parameter int OCC_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             atm_enb_n,
    input logic             out_valid,
    input logic             out_soc,
    input logic             in_valid,
    input logic             in_soc,
    input logic             sts_wr,
    input logic             sts_wdata,
    input logic             ovf_status,
    input logic             irq_en,
    input logic             irq,
    input logic [OCC_W-1:0] occ
);
    // R4
    stall_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        atm_enb_n |=> !out_valid);

    // R2
    soc_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_soc |-> out_valid);

    // R2
    soc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_soc |=> !out_soc);

    // R5
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(DEPTH));

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_status && !(sts_wr && !sts_wdata)) |=> ovf_status);

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && !sts_wdata && !(in_valid && in_soc)) |=> !ovf_status);

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && ovf_status));
endmodule

bind utopia_rx_cellq utopia_rx_cellq_chk #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .atm_enb_n(atm_enb_n), .out_valid(out_valid),
    .out_soc(out_soc), .in_valid(in_valid), .in_soc(in_soc), .sts_wr(sts_wr),
    .sts_wdata(sts_wdata), .ovf_status(ovf_status), .irq_en(irq_en),
    .irq(irq), .occ(occ)
);

// File: tb/utopia_rx_cellq_bench.sv
`timescale 1ns/1ps
module utopia_rx_cellq_bench;
    localparam int NB = 53;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_soc = 1'b0;
    logic [7:0] in_data = '0;
    logic       atm_enb_n = 1'b1;
    logic       out_valid, out_soc;
    logic [7:0] out_data;
    logic       sts_wr = 1'b0, sts_wdata = 1'b0;
    logic       ovf_status, irq;
    logic       irq_en = 1'b0;

    int errors = 0, checks = 0, cyc = 0;
    int enb_mode = 1;
    int exp_ids [0:63];
    int exp_n = 0, got = 0, mon_idx = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    utopia_rx_cellq u_utopia_rx_cellq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_soc(in_soc),
        .in_data(in_data), .atm_enb_n(atm_enb_n), .out_valid(out_valid),
        .out_soc(out_soc), .out_data(out_data), .sts_wr(sts_wr),
        .sts_wdata(sts_wdata), .ovf_status(ovf_status), .irq_en(irq_en), .irq(irq)
    );

    function automatic logic [7:0] pat(input int id, input int i);
        return 8'((id * 37 + i * 5 + 3) & 255);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // enable pattern driver
    always @(negedge clk) begin
        #1;
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (enb_mode)
            0: atm_enb_n <= 1'b0;
            1: atm_enb_n <= 1'b1;
            2: atm_enb_n <= (cyc % 3 == 2);
            default: atm_enb_n <= (lfsr[1:0] == 2'b00);
        endcase
    end

    // byte monitor: R2, R4, R5, R6
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (got >= exp_n) begin
                check(1'b0, "R6 unexpected cell byte", got, exp_n);
            end else begin
                check(out_data == pat(exp_ids[got], mon_idx), "R2/R5 data",
                      out_data, pat(exp_ids[got], mon_idx));
                check(out_soc == (mon_idx == 0), "R2 soc", out_soc, mon_idx == 0);
                mon_idx++;
                if (mon_idx == NB) begin
                    mon_idx = 0;
                    got++;
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    // send one cell; lat=1 runs the R3 latency checks, ovf_chk the R7 check
    task automatic send_cell(input int id, input bit drop, input bit gaps,
                             input bit lat, input bit ovf_chk);
        if (!drop) begin
            exp_ids[exp_n] = id;
            exp_n++;
        end
        for (int i = 0; i < NB; i++) begin
            @(negedge clk);
            if (lat) check(!out_valid, "R3 no early output", out_valid, 0);
            if (ovf_chk && i == 1) check(ovf_status, "R7 status set on drop", ovf_status, 1);
            #1;
            in_valid = 1'b1;
            in_soc   = (i == 0);
            in_data  = pat(id, i);
            if (gaps) begin
                @(negedge clk); #1;
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        if (lat) check(!out_valid, "R3 not before edge k+1", out_valid, 0);
        #1;
        in_valid = 1'b0;
        in_soc   = 1'b0;
        if (lat) begin
            @(negedge clk);
            check(out_valid && out_soc, "R3 byte 0 after edge k+1", out_valid, 1);
        end
    endtask

    task automatic wait_drain(input int n);
        for (int i = 0; i < 4000 && got < n; i++) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!out_valid && !out_soc, "R1 outputs idle", out_valid, 0);
        check(!ovf_status && !irq, "R1 status idle", ovf_status, 0);
        #1 rst_n = 1'b1;

        // R3 latency with enable always on
        enb_mode = 0;
        send_cell(1, 1'b0, 1'b0, 1'b1, 1'b0);
        wait_drain(exp_n);
        check(got == 1, "R3 cell delivered", got, 1);

        // R5/R6: fill four with output held, fifth dropped
        enb_mode = 1;
        for (int c = 0; c < 4; c++) send_cell(10 + c, 1'b0, c[0], 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        check(got == 1, "R4 no output while held", got, 1);
        check(!ovf_status, "R7 no status before drop", ovf_status, 0);
        send_cell(99, 1'b1, 1'b0, 1'b0, 1'b1);
        // R4 stall sweep while draining
        enb_mode = 2;
        wait_drain(exp_n);
        check(got == 5, "R6 four stored cells delivered", got, 5);
        check(ovf_status, "R7 status sticky", ovf_status, 1);

        // R9 interrupt gating
        @(negedge clk); #1 irq_en = 1'b0; #1;
        check(!irq, "R9 irq masked", irq, 0);
        #1 irq_en = 1'b1; #1;
        check(irq, "R9 irq raised", irq, 1);

        // R8 write 1 no effect, write 0 clears
        @(negedge clk); #1 sts_wr = 1'b1; sts_wdata = 1'b1;
        @(negedge clk);
        check(ovf_status, "R8 write 1 keeps status", ovf_status, 1);
        #1 sts_wdata = 1'b0;
        @(negedge clk);
        check(!ovf_status, "R8 write 0 clears", ovf_status, 0);
        check(!irq, "R9 irq follows clear", irq, 0);
        #1 sts_wr = 1'b0;
        #1 irq_en = 1'b0; #1;
        check(!irq, "R9 irq low with both low", irq, 0);

        // R10 stray bytes without soc
        enb_mode = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #1;
            in_valid = 1'b1; in_soc = 1'b0; in_data = 8'(i);
        end
        @(negedge clk); #1 in_valid = 1'b0;
        repeat (10) @(negedge clk);
        check(got == 5, "R10 stray bytes ignored", got, 5);
        send_cell(40, 1'b0, 1'b0, 1'b1, 1'b0);
        wait_drain(exp_n);
        check(got == 6, "R10 next cell intact", got, 6);

        // R5 concurrent flow with pseudo-random stalls
        enb_mode = 3;
        for (int c = 0; c < 8; c++) send_cell(50 + c, 1'b0, 1'b1, 1'b0, 1'b0);
        wait_drain(exp_n);
        check(got == 14, "R5 all cells in order", got, 14);
        check(mon_idx == 0, "R2 no partial cell", mon_idx, 0);
        check(!ovf_status, "R7 no spurious overflow", ovf_status, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule